// File: doc/BRIEF.md
# Four-Lane Sobel Gradient Unit

This block sits after an image smoothing stage and turns a raster stream of 8-bit grey pixels, delivered four at a time in packed words, into edge-strength and edge-orientation values. For every pixel it evaluates the horizontal and vertical 3x3 Sobel kernels, adds their absolute values into a saturated magnitude, and reduces the orientation to one of four sectors. Four results leave per accepted cycle, all four taken from one shared window three rows tall and six pixels wide.

Two earlier rows are kept in line stores that hold one packed four-pixel word per entry, so storage does not grow with the lane count. Output begins once one full row plus one word has been taken in. Neighbours that fall outside the frame read as zero. The weight of two in the kernel is a one-bit shift and the sector tests use shift-and-add constants, so the datapath has no multiplier. To emit the last word of each row and the last row of each frame, the block inserts pad steps of its own (one per row and one full row per frame) during which it does not accept input.

Both sides use a valid/ready handshake. A result that is not taken stays on the outputs unchanged, and the whole pipeline pauses while it waits.

Top module: `sobel_quad_gradient`

## Requirements
- R1: Input word lane k (bits [8k+7:8k]) holds the pixel in column 4w+k of word w; the leftmost pixel is lane 0. Output lane k of `out_mag` (bits [10k+9:10k]) and of `out_dir` (bits [2k+1:2k]) belongs to that same pixel.
- R2: With p(r,c) the pixel at row r and column c, Gx is the sum over the right column minus the left column with weights 1,2,1 from top to bottom, Gy is the sum over the bottom row minus the top row with weights 1,2,1 from left to right, and the magnitude is |Gx|+|Gy| limited to 1023.
- R3: The direction code is 0 when Gx and Gy are both zero or when 128·|Gy| < 53·|Gx|; 2 when 128·|Gy| > 309·|Gx|; otherwise 1 when Gx and Gy have the same sign and 3 when they differ.
- R4: Pixels above the first row, below the last row, left of the first column and right of the last column count as zero.
- R5: With input always valid and output always ready, the first output is visible WORDS+3 cycles after the cycle in which the first beat of a frame is accepted (WORDS = IMG_W/4).
- R6: Each frame takes IMG_H·WORDS input beats and gives IMG_H·WORDS output beats; with no stalls the last output of a frame is visible (IMG_H+1)·(WORDS+1) cycles after the first input of that frame is accepted, and `in_ready` is low during the inserted pad steps.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_mag` and `out_dir` hold their values into the next cycle.
- R8: Gaps in `in_valid` and in `out_ready` change only the timing, never the values or the order of the results.
- R9: While reset is active and in the first cycles after its release, `out_valid` and `in_ready` are low; afterwards `in_ready` rises with the raster at the start of a frame.
- R10: Each frame's results depend only on that frame's pixels; line-store contents left from the previous frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes the input word this cycle |
| in_data | input | 32 | Four packed pixels, lane 0 leftmost |
| out_valid | output | 1 | Four results present |
| out_ready | input | 1 | Consumer takes the results this cycle |
| out_mag | output | 40 | Four 10-bit saturated magnitudes |
| out_dir | output | 8 | Four 2-bit direction codes |

## Verification
The assertions take for granted that input beats arrive as whole frames in raster order, exactly IMG_H·WORDS of them per frame, so that input and output beat counts can be compared across frames, and that the consumer may drop `out_ready` at any time. The stimulus keeps to this by feeding each frame word by word in raster order, never starting the next frame until every result of the current one has been taken, while raising `in_valid` and `out_ready` at random rates. Each frame's expected results come from a pixel-level model of the kernel, the saturation and the sector tests.

// File: rtl/sgu_pkg.sv
package sgu_pkg;

  // Quantised gradient orientation (sector of the gradient vector).
  typedef enum logic [1:0] {
    DIR_H    = 2'd0,
    DIR_D45  = 2'd1,
    DIR_V    = 2'd2,
    DIR_D135 = 2'd3
  } grad_dir_e;

endpackage

// File: rtl/sgu_dir_quant.sv
module sgu_dir_quant
  import sgu_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [AW-1:0] ax,
  input  logic [AW-1:0] ay,
  input  logic          neg_x,
  input  logic          neg_y,
  output grad_dir_e     dir
);

  // ay*128 against ax*53/128 and ax*309/128 scaled by 128.
  localparam int unsigned QW = AW + 9;

  logic [QW-1:0] ax_ext;
  logic [QW-1:0] ay_scaled;
  logic [QW-1:0] lim_lo;
  logic [QW-1:0] lim_hi;

  always_comb begin
    ax_ext    = QW'(ax);
    ay_scaled = QW'(ay) << 7;
    lim_lo    = (ax_ext << 5) + (ax_ext << 4) + (ax_ext << 2) + ax_ext;
    lim_hi    = (ax_ext << 8) + lim_lo;
  end

  always_comb begin
    if (ax == '0 && ay == '0) begin
      dir = DIR_H;
    end else if (ay_scaled < lim_lo) begin
      dir = DIR_H;
    end else if (ay_scaled > lim_hi) begin
      dir = DIR_V;
    end else if (neg_x == neg_y) begin
      dir = DIR_D45;
    end else begin
      dir = DIR_D135;
    end
  end

endmodule

// File: rtl/sgu_kernel.sv
module sgu_kernel
  import sgu_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned SW   = PIX_W + 2,
  localparam int unsigned GW   = SW + 1
) (
  input  logic [3*PIX_W-1:0] row_top,
  input  logic [3*PIX_W-1:0] row_bot,
  input  logic [PIX_W-1:0]   mid_left,
  input  logic [PIX_W-1:0]   mid_right,
  output logic [SW-1:0]      mag,
  output grad_dir_e          dir
);

  logic [PIX_W-1:0] t0, t1, t2, b0, b1, b2;
  logic [SW-1:0]    sum_left, sum_right, sum_top, sum_bot;
  logic signed [GW-1:0] gx, gy;
  logic [SW-1:0]    abs_x, abs_y;
  logic [SW:0]      total;

  assign t0 = row_top[0*PIX_W +: PIX_W];
  assign t1 = row_top[1*PIX_W +: PIX_W];
  assign t2 = row_top[2*PIX_W +: PIX_W];
  assign b0 = row_bot[0*PIX_W +: PIX_W];
  assign b1 = row_bot[1*PIX_W +: PIX_W];
  assign b2 = row_bot[2*PIX_W +: PIX_W];

  // Weight two is a one-bit left shift.
  always_comb begin
    sum_left  = SW'(t0) + (SW'(mid_left)  << 1) + SW'(b0);
    sum_right = SW'(t2) + (SW'(mid_right) << 1) + SW'(b2);
    sum_top   = SW'(t0) + (SW'(t1) << 1) + SW'(t2);
    sum_bot   = SW'(b0) + (SW'(b1) << 1) + SW'(b2);
    gx        = $signed({1'b0, sum_right}) - $signed({1'b0, sum_left});
    gy        = $signed({1'b0, sum_bot})   - $signed({1'b0, sum_top});
    abs_x     = gx[GW-1] ? SW'(-gx) : SW'(gx);
    abs_y     = gy[GW-1] ? SW'(-gy) : SW'(gy);
    total     = {1'b0, abs_x} + {1'b0, abs_y};
    mag       = total[SW] ? '1 : total[SW-1:0];
  end

  sgu_dir_quant #(
    .AW(SW)
  ) u_quant (
    .ax   (abs_x),
    .ay   (abs_y),
    .neg_x(gx[GW-1]),
    .neg_y(gy[GW-1]),
    .dir  (dir)
  );

endmodule

// File: rtl/sgu_window.sv
module sgu_window #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned WIN_W  = PIX_W * (LANES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              left_zero,
  input  logic [WORD_W-1:0] cur_top,
  input  logic [WORD_W-1:0] cur_mid,
  input  logic [WORD_W-1:0] cur_bot,
  output logic [WIN_W-1:0]  win_top,
  output logic [WIN_W-1:0]  win_mid,
  output logic [WIN_W-1:0]  win_bot
);

  // Centre word of the window, one step behind the current column.
  logic [WORD_W-1:0] ctr_top_q, ctr_mid_q, ctr_bot_q;
  // Rightmost pixel of the word two steps behind.
  logic [PIX_W-1:0]  edge_top_q, edge_mid_q, edge_bot_q;
  logic [PIX_W-1:0]  edge_top, edge_mid, edge_bot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_top_q  <= '0;
      ctr_mid_q  <= '0;
      ctr_bot_q  <= '0;
      edge_top_q <= '0;
      edge_mid_q <= '0;
      edge_bot_q <= '0;
    end else if (shift_en) begin
      ctr_top_q  <= cur_top;
      ctr_mid_q  <= cur_mid;
      ctr_bot_q  <= cur_bot;
      edge_top_q <= ctr_top_q[WORD_W-1 -: PIX_W];
      edge_mid_q <= ctr_mid_q[WORD_W-1 -: PIX_W];
      edge_bot_q <= ctr_bot_q[WORD_W-1 -: PIX_W];
    end
  end

  always_comb begin
    edge_top = left_zero ? '0 : edge_top_q;
    edge_mid = left_zero ? '0 : edge_mid_q;
    edge_bot = left_zero ? '0 : edge_bot_q;
    win_top  = {cur_top[PIX_W-1:0], ctr_top_q, edge_top};
    win_mid  = {cur_mid[PIX_W-1:0], ctr_mid_q, edge_mid};
    win_bot  = {cur_bot[PIX_W-1:0], ctr_bot_q, edge_bot};
  end

endmodule

// File: rtl/sgu_line_store.sv
module sgu_line_store #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned WORDS = 8,
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned IW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     idx,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] row_up1,
  output logic [WORD_W-1:0] row_up2
);

  logic [WORD_W-1:0] line_a [WORDS];
  logic [WORD_W-1:0] line_b [WORDS];

  assign row_up1 = line_a[idx];
  assign row_up2 = line_b[idx];

  // Storage arrays are not reset; reads before the first write are masked.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_b[idx] <= line_a[idx];
      line_a[idx] <= wr_word;
    end
  end

endmodule

// File: rtl/sgu_raster_ctrl.sv
module sgu_raster_ctrl #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned ROWS  = 8,
  localparam int unsigned CW = $clog2(WORDS + 1),
  localparam int unsigned RW = $clog2(ROWS + 1),
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_free,
  output logic          step,
  output logic          in_ready,
  output logic          pad_col,
  output logic          pad_row,
  output logic          emit,
  output logic          top_zero,
  output logic          left_zero,
  output logic [IW-1:0] word_idx
);

  localparam logic [CW-1:0] COL_PAD = CW'(WORDS);
  localparam logic [RW-1:0] ROW_PAD = RW'(ROWS);

  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          live_q;
  logic          pad;

  always_comb begin
    pad_col   = (col_q == COL_PAD);
    pad_row   = (row_q == ROW_PAD);
    pad       = pad_col || pad_row;
    in_ready  = live_q && out_free && !pad;
    step      = live_q && out_free && (pad || in_valid);
    emit      = (row_q != '0) && (col_q != '0);
    top_zero  = (row_q <= RW'(1));
    left_zero = (col_q == CW'(1));
    word_idx  = pad_col ? '0 : IW'(col_q);
  end

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (step) begin
      if (pad_col) begin
        col_d = '0;
        row_d = pad_row ? '0 : row_q + RW'(1);
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      live_q <= 1'b0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      live_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sobel_quad_gradient.sv
module sobel_quad_gradient
  import sgu_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned IMG_W = 32,
  parameter int unsigned IMG_H = 8,
  localparam int unsigned WORDS  = IMG_W / LANES,
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned MAG_W  = PIX_W + 2,
  localparam int unsigned WIN_W  = PIX_W * (LANES + 2),
  localparam int unsigned IW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WORD_W-1:0]      in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*MAG_W-1:0] out_mag,
  output logic [LANES*2-1:0]     out_dir
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe_q[1];

  logic              step, pad_col, pad_row, pad_pos, emit, top_zero, left_zero;
  logic              out_free, load_out, wr_en;
  logic [IW-1:0]     word_idx;
  logic [WORD_W-1:0] row_up1, row_up2;
  logic [WORD_W-1:0] cur_top, cur_mid, cur_bot;
  logic [WIN_W-1:0]  win_top, win_mid, win_bot;

  logic                   out_valid_q, out_valid_d;
  logic [LANES*MAG_W-1:0] mag_q, mag_d;
  logic [LANES*2-1:0]     dir_q, dir_d;

  assign out_free = !out_valid_q || out_ready;
  assign pad_pos  = pad_col || pad_row;
  assign wr_en    = step && !pad_pos;
  assign load_out = step && emit;

  sgu_raster_ctrl #(
    .WORDS(WORDS),
    .ROWS (IMG_H)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s),
    .in_valid (in_valid),
    .out_free (out_free),
    .step     (step),
    .in_ready (in_ready),
    .pad_col  (pad_col),
    .pad_row  (pad_row),
    .emit     (emit),
    .top_zero (top_zero),
    .left_zero(left_zero),
    .word_idx (word_idx)
  );

  sgu_line_store #(
    .PIX_W(PIX_W),
    .LANES(LANES),
    .WORDS(WORDS)
  ) u_lines (
    .clk    (clk),
    .wr_en  (wr_en),
    .idx    (word_idx),
    .wr_word(in_data),
    .row_up1(row_up1),
    .row_up2(row_up2)
  );

  // Border masking of the incoming column.
  always_comb begin
    cur_top = (top_zero || pad_col) ? '0 : row_up2;
    cur_mid = pad_col ? '0 : row_up1;
    cur_bot = pad_pos ? '0 : in_data;
  end

  sgu_window #(
    .PIX_W(PIX_W),
    .LANES(LANES)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_s),
    .shift_en (step),
    .left_zero(left_zero),
    .cur_top  (cur_top),
    .cur_mid  (cur_mid),
    .cur_bot  (cur_bot),
    .win_top  (win_top),
    .win_mid  (win_mid),
    .win_bot  (win_bot)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    grad_dir_e lane_dir;

    sgu_kernel #(
      .PIX_W(PIX_W)
    ) u_kernel (
      .row_top  (win_top[k*PIX_W +: 3*PIX_W]),
      .row_bot  (win_bot[k*PIX_W +: 3*PIX_W]),
      .mid_left (win_mid[k*PIX_W +: PIX_W]),
      .mid_right(win_mid[(k+2)*PIX_W +: PIX_W]),
      .mag      (mag_d[k*MAG_W +: MAG_W]),
      .dir      (lane_dir)
    );

    assign dir_d[k*2 +: 2] = lane_dir;
  end

  always_comb begin
    out_valid_d = out_valid_q;
    if (load_out) begin
      out_valid_d = 1'b1;
    end else if (out_ready) begin
      out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid_q <= 1'b0;
      mag_q       <= '0;
      dir_q       <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      if (load_out) begin
        mag_q <= mag_d;
        dir_q <= dir_d;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_mag   = mag_q;
  assign out_dir   = dir_q;

endmodule

// File: rtl/sobel_quad_gradient_chk.sv
module sobel_quad_gradient_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned MAG_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*MAG_W-1:0] out_mag,
  input logic [LANES*2-1:0]     out_dir,
  input logic                   pad_pos
);

  logic [31:0] in_beats_q, out_beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_beats_q  <= '0;
      out_beats_q <= '0;
    end else begin
      if (in_valid && in_ready) in_beats_q <= in_beats_q + 32'd1;
      if (out_valid && out_ready) out_beats_q <= out_beats_q + 32'd1;
    end
  end

  // R7: a result not taken stays put.
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_dir)));

  // R6: no input is taken on an internally generated pad step.
  p_pad_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pos |-> !in_ready);

  // R6: every result follows at least one more accepted input beat.
  p_out_after_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_beats_q < in_beats_q));

  // R3: a zero magnitude always comes with direction code 0.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    p_zero_mag_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mag[k*MAG_W +: MAG_W] == '0) |-> (out_dir[k*2 +: 2] == 2'd0));
  end

endmodule

bind sobel_quad_gradient sobel_quad_gradient_chk #(
  .LANES(LANES),
  .MAG_W(MAG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_mag  (out_mag),
  .out_dir  (out_dir),
  .pad_pos  (pad_pos)
);

// File: tb/tb_sobel_quad_gradient.sv
`timescale 1ns/1ps
module tb_sobel_quad_gradient;

  localparam int PIX_W = 8;
  localparam int LANES = 4;
  localparam int IMG_W = 32;
  localparam int IMG_H = 8;
  localparam int WORDS = IMG_W / LANES;
  localparam int MAGW  = PIX_W + 2;
  localparam int NBEAT = IMG_H * WORDS;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [LANES*PIX_W-1:0] in_data = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [LANES*MAGW-1:0] out_mag;
  logic [LANES*2-1:0]    out_dir;

  always #2.5 clk = ~clk;

  sobel_quad_gradient #(
    .PIX_W(PIX_W), .LANES(LANES), .IMG_W(IMG_W), .IMG_H(IMG_H)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_mag(out_mag), .out_dir(out_dir)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int img [IMG_H][IMG_W];
  logic [LANES*MAGW-1:0] e_mag [NBEAT];
  logic [LANES*2-1:0]    e_dir [NBEAT];
  logic [LANES*MAGW-1:0] first_mag;
  logic [LANES*2-1:0]    first_dir;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int px(int r, int c);
    if (r < 0 || r >= IMG_H || c < 0 || c >= IMG_W) return 0;
    return img[r][c];
  endfunction

  task automatic model(input int r, input int c, output int m, output int d);
    int gx, gy, ax, ay;
    gx = px(r-1,c+1) + 2*px(r,c+1) + px(r+1,c+1)
       - (px(r-1,c-1) + 2*px(r,c-1) + px(r+1,c-1));
    gy = px(r+1,c-1) + 2*px(r+1,c) + px(r+1,c+1)
       - (px(r-1,c-1) + 2*px(r-1,c) + px(r-1,c+1));
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    m  = (ax + ay > 1023) ? 1023 : ax + ay;
    if (ax == 0 && ay == 0)        d = 0;
    else if (ay*128 < ax*53)       d = 0;
    else if (ay*128 > ax*309)      d = 2;
    else if ((gx < 0) == (gy < 0)) d = 1;
    else                           d = 3;
  endtask

  task automatic fill_image(input int mode);
    for (int r = 0; r < IMG_H; r++) begin
      for (int c = 0; c < IMG_W; c++) begin
        case (mode)
          1: img[r][c] = 255;
          2: img[r][c] = 0;
          3: img[r][c] = c * 7;
          4: img[r][c] = (((r + c) % 4) == 0) ? 200 : 20;
          5: img[r][c] = ($urandom_range(1) == 1) ? 255 : 0;
          default: img[r][c] = $urandom_range(255);
        endcase
      end
    end
    for (int b = 0; b < NBEAT; b++) begin
      for (int k = 0; k < LANES; k++) begin
        int m, d;
        model(b / WORDS, (b % WORDS) * LANES + k, m, d);
        e_mag[b][k*MAGW +: MAGW] = MAGW'(m);
        e_dir[b][k*2 +: 2]       = 2'(d);
      end
    end
  endtask

  function automatic logic [LANES*PIX_W-1:0] word_of(int b);
    logic [LANES*PIX_W-1:0] w;
    for (int k = 0; k < LANES; k++)
      w[k*PIX_W +: PIX_W] = PIX_W'(img[b / WORDS][(b % WORDS) * LANES + k]);
    return w;
  endfunction

  task automatic run_frame(input int mode, input string tag,
                           input int p_in, input int p_out, input bit measure);
    int in_idx = 0, out_idx = 0, cyc = 0;
    int first_acc = -1, first_out = -1, last_out = -1;
    bit prev_hold = 1'b0;
    logic [LANES*MAGW-1:0] held_mag;
    logic [LANES*2-1:0]    held_dir;
    fill_image(mode);
    while (out_idx < NBEAT) begin
      @(negedge clk);
      cyc++;
      in_valid  = (in_idx < NBEAT) && ($urandom_range(99) < p_in);
      in_data   = in_valid ? word_of(in_idx) : '0;
      out_ready = ($urandom_range(99) < p_out);
      #1;
      if (prev_hold) begin
        chk(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
        chk(out_mag == held_mag && out_dir == held_dir, "R7", "data held",
            out_mag, held_mag);
      end
      prev_hold = out_valid && !out_ready;
      held_mag  = out_mag;
      held_dir  = out_dir;
      if (in_valid && in_ready) begin
        if (first_acc < 0) first_acc = cyc;
        in_idx++;
      end
      if (out_valid && first_out < 0) first_out = cyc;
      if (out_valid && out_ready) begin
        if (out_idx == 0) begin
          first_mag = out_mag;
          first_dir = out_dir;
        end
        for (int k = 0; k < LANES; k++) begin
          chk(out_mag[k*MAGW +: MAGW] == e_mag[out_idx][k*MAGW +: MAGW],
              $sformatf("%s/R2", tag), $sformatf("mag beat %0d lane %0d", out_idx, k),
              out_mag[k*MAGW +: MAGW], e_mag[out_idx][k*MAGW +: MAGW]);
          chk(out_dir[k*2 +: 2] == e_dir[out_idx][k*2 +: 2],
              $sformatf("%s/R3", tag), $sformatf("dir beat %0d lane %0d", out_idx, k),
              out_dir[k*2 +: 2], e_dir[out_idx][k*2 +: 2]);
        end
        out_idx++;
        last_out = cyc;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    chk(in_idx == NBEAT, "R6", "input beats per frame", in_idx, NBEAT);
    if (measure) begin
      chk(first_out - first_acc == WORDS + 3, "R5", "first output latency",
          first_out - first_acc, WORDS + 3);
      chk(last_out - first_acc == (IMG_H + 1) * (WORDS + 1), "R6", "frame span",
          last_out - first_acc, (IMG_H + 1) * (WORDS + 1));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R9", "in_ready in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

    // Flat bright frame: only the border pixels see an edge.
    run_frame(1, "R4", 70, 70, 1'b0);
    chk(first_mag[0 +: MAGW] == 10'd1023, "R4", "corner mag saturated",
        first_mag[0 +: MAGW], 1023);
    chk(first_dir[0 +: 2] == 2'd1, "R4", "corner dir", first_dir[0 +: 2], 1);
    chk(first_mag[MAGW +: MAGW] == 10'd1020, "R2", "top edge mag",
        first_mag[MAGW +: MAGW], 1020);
    chk(first_dir[2 +: 2] == 2'd2, "R3", "top edge dir", first_dir[2 +: 2], 2);

    // Dark frame right after: nothing may leak from the line stores.
    run_frame(2, "R10", 70, 70, 1'b0);
    // Horizontal ramp with full flow: lane order and timing.
    run_frame(3, "R1", 100, 100, 1'b1);
    run_frame(4, "R3", 80, 60, 1'b0);
    run_frame(5, "R3", 90, 50, 1'b0);
    for (int f = 0; f < 6; f++) begin
      run_frame(0, "R8", 30 + f * 12, 100 - f * 13, 1'b0);
    end
    run_frame(0, "R5", 100, 100, 1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog expired actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule